// File: doc/BRIEF.md
# Memory-Fed Melody Sequencer

The sequencer plays a tune stored as a list of two-byte note words in a byte-wide memory with a synchronous read port. A controller gives it a start address and a 5-bit tempo code and pulses start. The block then reads the note words in order. For each note it drives a square-wave tone on one output pin for a time set by the tempo and the note's length code. A note whose pitch code marks a rest leaves the pin low for its length instead.

Playback ends after the note that carries the last-note flag has finished, or at once when a stop request arrives. The next note word is read while the current note is still sounding, so notes follow each other with no idle cycles. A one-cycle end-of-music pulse marks the first cycle of the flagged note. Busy stays high from the cycle after start until playback ends.

At the default 4.096 MHz clock, one duration tick is 6144 clocks (1.5 ms). A tone half-period is 32·(N+2) clocks, which gives a pitch of 64 kHz/(N+2). Both constants are parameters.

Top module: `mel_seq`

## Requirements
- R1: After reset, busy, tone_out, music_end and mem_rd are all low.
- R2: A start pulse while idle raises busy on the next cycle. The first memory read is at start_addr. Every further read is at the previous read address plus one, including across note words, and a restart after playback has ended begins again at the new start_addr.
- R3: A start pulse while busy is high is ignored. Playback, read addresses and timing continue unchanged.
- R4: A note word is byte 0 followed by byte 1. Byte 0 carries the last-note flag in bit 7 and the length code L in bits 5:0. Byte 1 is the pitch code N. A note lasts exactly TICK_CLKS·(T+1)·(L+1) clocks, where T is the tempo code latched at start. Consecutive notes play back to back, so busy is high for 4 + the sum of note durations clocks.
- R5: A length code of 0 lasts as long as a length code of 1, and a tempo code of 0 lasts as long as a tempo code of 1.
- R6: For a non-rest note, tone_out starts low at the first cycle of the note. It then toggles every HALF_MUL·(N+2) clocks, giving high and low phases of equal length.
- R7: A pitch code with bits 7:2 all zero is a rest, and tone_out stays low for the whole note. Bits 1:0 of such a code have no effect.
- R8: music_end is high for exactly one cycle, the first cycle of a note with byte 0 bit 7 set. Busy falls right after that note ends, and no memory read follows it. Byte 0 bit 6 has no effect.
- R9: A stop pulse while busy drops busy, tone_out and music_end on the next cycle, and no further memory reads are issued. This holds even when the stop coincides with the hand-over from one note to the next.
- R10: tone_out is low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin playback (accepted only while idle) |
| start_addr | input | ADDR_W | Address of the first note word |
| tempo | input | 5 | Tempo code T, latched on start |
| stop | input | 1 | Halt playback immediately |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_data | input | 8 | Read data, valid the cycle after mem_rd |
| tone_out | output | 1 | Square-wave tone, low when silent |
| busy | output | 1 | High while a melody is in progress |
| music_end | output | 1 | One-cycle pulse at the start of the last note |

## Verification
The collision that matters is a stop request in the same cycle that a note ends and the prefetched next note would be loaded. The load, its end-of-music pulse and the read of the following word all compete with the halt in that cycle. The bench times the stop to that exact cycle, counting from start with the known duration of the first note. It then requires busy and tone low on the next cycle and no further read, where an unstopped run would have issued one. A second overlap, a start arriving mid-note, is judged by the read address log and an unchanged busy length.

// File: rtl/mel_pkg.sv
package mel_pkg;

  // fetch phase of the note-word reader
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } fetch_ph_t;

  // a code of zero counts like a code of one
  function automatic logic [4:0] tempo_eff(input logic [4:0] t);
    return (t == 5'd0) ? 5'd1 : t;
  endfunction

  function automatic logic [5:0] len_eff(input logic [5:0] l);
    return (l == 6'd0) ? 6'd1 : l;
  endfunction

  // upper six pitch bits clear means silence
  function automatic logic pitch_is_rest(input logic [7:0] n);
    return (n[7:2] == 6'd0);
  endfunction

  // clocks between tone toggles
  function automatic int unsigned half_clks(input logic [7:0] n, input int unsigned mul);
    return mul * (32'(n) + 32'd2);
  endfunction

endpackage

// File: rtl/mel_fetch.sv
module mel_fetch #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              halt_i,
  input  logic              take_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              nxt_vld_o,
  output logic              nxt_last_o,
  output logic [5:0]        nxt_len_o,
  output logic [7:0]        nxt_pitch_o
);
  import mel_pkg::*;

  fetch_ph_t         ph_q;
  logic              active_q, ended_q, vld_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              lo_last_q;
  logic [5:0]        lo_len_q;
  logic              issue_w;

  assign issue_w = active_q && !ended_q && (ph_q == PH_IDLE) && (!vld_q || take_i)
                   && !halt_i && !begin_i;
  assign mem_rd_o   = issue_w || ((ph_q == PH_LO) && !halt_i && !begin_i);
  assign mem_addr_o = ptr_q;
  assign nxt_vld_o  = vld_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q        <= PH_IDLE;
      active_q    <= 1'b0;
      ended_q     <= 1'b0;
      vld_q       <= 1'b0;
      ptr_q       <= '0;
      lo_last_q   <= 1'b0;
      lo_len_q    <= '0;
      nxt_last_o  <= 1'b0;
      nxt_len_o   <= '0;
      nxt_pitch_o <= '0;
    end else if (begin_i) begin
      ptr_q    <= start_addr_i;
      active_q <= 1'b1;
      ended_q  <= 1'b0;
      vld_q    <= 1'b0;
      ph_q     <= PH_IDLE;
    end else if (halt_i) begin
      active_q <= 1'b0;
      vld_q    <= 1'b0;
      ph_q     <= PH_IDLE;
    end else begin
      if (take_i) vld_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (issue_w) begin
          ptr_q <= ptr_q + 1'b1;
          ph_q  <= PH_LO;
        end
        PH_LO: begin
          lo_last_q <= mem_data_i[7];
          lo_len_q  <= mem_data_i[5:0];
          ptr_q     <= ptr_q + 1'b1;
          ph_q      <= PH_HI;
        end
        PH_HI: begin
          nxt_last_o  <= lo_last_q;
          nxt_len_o   <= lo_len_q;
          nxt_pitch_o <= mem_data_i;
          vld_q       <= 1'b1;
          ended_q     <= lo_last_q;
          ph_q        <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mel_timer.sv
module mel_timer #(
  parameter int TICK_CLKS = 6144
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       clear_i,
  input  logic [4:0] tempo_i,
  input  logic [5:0] len_i,
  output logic       done_o
);
  import mel_pkg::*;

  localparam int TW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;

  logic          run_q;
  logic [TW-1:0] tick_q;
  logic [4:0]    tp_q, tp_max_q;
  logic [5:0]    l_q, l_max_q;
  logic          wrap_w, tp_end_w, l_end_w;

  assign wrap_w   = run_q && (tick_q == TW'(TICK_CLKS - 1));
  assign tp_end_w = (tp_q == tp_max_q);
  assign l_end_w  = (l_q == l_max_q);
  assign done_o   = wrap_w && tp_end_w && l_end_w;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      run_q    <= 1'b0;
      tick_q   <= '0;
      tp_q     <= '0;
      l_q      <= '0;
      tp_max_q <= '0;
      l_max_q  <= '0;
    end else if (load_i) begin
      run_q    <= 1'b1;
      tick_q   <= '0;
      tp_q     <= '0;
      l_q      <= '0;
      tp_max_q <= tempo_eff(tempo_i);
      l_max_q  <= len_eff(len_i);
    end else if (run_q) begin
      tick_q <= wrap_w ? '0 : tick_q + 1'b1;
      if (wrap_w) begin
        if (tp_end_w) begin
          tp_q <= '0;
          if (l_end_w) run_q <= 1'b0;
          else         l_q   <= l_q + 1'b1;
        end else begin
          tp_q <= tp_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mel_tone.sv
module mel_tone #(
  parameter int HALF_MUL = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic       clear_i,
  input  logic [7:0] pitch_i,
  output logic       tone_o
);
  import mel_pkg::*;

  localparam int HW = $clog2(HALF_MUL * 257 + 1);

  logic          sound_q, out_q;
  logic [HW-1:0] half_q, cnt_q;

  assign tone_o = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      sound_q <= 1'b0;
      out_q   <= 1'b0;
      cnt_q   <= '0;
      half_q  <= '0;
    end else if (load_i) begin
      sound_q <= !pitch_is_rest(pitch_i);
      half_q  <= HW'(half_clks(pitch_i, HALF_MUL));
      cnt_q   <= '0;
      out_q   <= 1'b0;
    end else if (sound_q) begin
      if (cnt_q == half_q - 1'b1) begin
        cnt_q <= '0;
        out_q <= !out_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mel_seq.sv
module mel_seq #(
  parameter int ADDR_W    = 18,
  parameter int TICK_CLKS = 6144,
  parameter int HALF_MUL  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [4:0]        tempo,
  input  logic              stop,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_data,
  output logic              tone_out,
  output logic              busy,
  output logic              music_end
);
  import mel_pkg::*;

  logic       busy_q, note_on, cur_last, cur_rest, end_q;
  logic [4:0] tempo_q;
  logic       begin_w, stop_w, take_w, note_done, finish_w, halt_w, clr_w;
  logic       nxt_vld, nxt_last;
  logic [5:0] nxt_len;
  logic [7:0] nxt_pitch;

  assign begin_w  = start && !busy_q;
  assign stop_w   = stop && busy_q;
  assign take_w   = busy_q && !stop_w && nxt_vld && (!note_on || note_done);
  assign finish_w = note_on && note_done && cur_last;
  assign halt_w   = stop_w || finish_w;
  assign clr_w    = stop_w || (note_done && !take_w);

  mel_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .begin_i(begin_w), .start_addr_i(start_addr),
    .halt_i(halt_w), .take_i(take_w), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .nxt_vld_o(nxt_vld), .nxt_last_o(nxt_last),
    .nxt_len_o(nxt_len), .nxt_pitch_o(nxt_pitch)
  );

  mel_timer #(.TICK_CLKS(TICK_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(take_w), .clear_i(clr_w),
    .tempo_i(tempo_q), .len_i(nxt_len), .done_o(note_done)
  );

  mel_tone #(.HALF_MUL(HALF_MUL)) u_tone (
    .clk(clk), .rst_n(rst_n), .load_i(take_w), .clear_i(clr_w),
    .pitch_i(nxt_pitch), .tone_o(tone_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      note_on  <= 1'b0;
      cur_last <= 1'b0;
      cur_rest <= 1'b0;
      end_q    <= 1'b0;
      tempo_q  <= '0;
    end else begin
      end_q <= take_w && nxt_last;
      if (begin_w) begin
        busy_q  <= 1'b1;
        note_on <= 1'b0;
        tempo_q <= tempo;
      end else if (stop_w) begin
        busy_q  <= 1'b0;
        note_on <= 1'b0;
      end else if (take_w) begin
        note_on  <= 1'b1;
        cur_last <= nxt_last;
        cur_rest <= pitch_is_rest(nxt_pitch);
      end else if (note_done) begin
        note_on <= 1'b0;
        if (cur_last) busy_q <= 1'b0;
      end
    end
  end

  assign busy      = busy_q;
  assign music_end = end_q;
endmodule

// File: rtl/mel_seq_chk.sv
module mel_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop,
  input logic              busy,
  input logic              tone_out,
  input logic              music_end,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              note_on,
  input logic              cur_rest,
  input logic              note_done
);
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tone_out);

  assert_no_fetch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd);

  assert_stop_halts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && busy) |=> (!busy && !tone_out && !music_end));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_end_in_note_R8: assert property (@(posedge clk) disable iff (!rst_n)
    music_end |-> (busy && note_on));

  assert_end_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    music_end |=> !music_end);

  assert_rest_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (note_on && cur_rest) |-> !tone_out);

  assert_done_in_note_R4: assert property (@(posedge clk) disable iff (!rst_n)
    note_done |-> note_on);
endmodule

bind mel_seq mel_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .busy(busy), .tone_out(tone_out),
  .music_end(music_end), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .note_on(note_on), .cur_rest(cur_rest), .note_done(note_done)
);

// File: tb/mel_seq_tb.sv
module mel_seq_tb;
  localparam int AW   = 8;
  localparam int TICK = 16;
  localparam int MUL  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [4:0]    tempo = '0;
  logic          stop = 1'b0;
  logic          mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_data;
  logic          tone_out, busy, music_end;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int rd_cnt = 0, end_cnt = 0;
  logic [AW-1:0] rd_log [0:15];
  logic [7:0] rom [0:255];

  always #10 clk = ~clk;

  mel_seq #(.ADDR_W(AW), .TICK_CLKS(TICK), .HALF_MUL(MUL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .tempo(tempo),
    .stop(stop), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .tone_out(tone_out), .busy(busy), .music_end(music_end)
  );

  always_ff @(posedge clk) mem_data <= rom[mem_addr];

  always @(negedge clk) begin
    if (mem_rd) begin
      if (rd_cnt < 16) rd_log[rd_cnt] = mem_addr;
      rd_cnt++;
    end
    if (music_end) end_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dur(input int t, input int l);
    int te = (t == 0) ? 1 : t;
    int le = (l == 0) ? 1 : l;
    return TICK * (te + 1) * (le + 1);
  endfunction

  // leaves the bench at the falling edge of the first cycle after start is taken
  task automatic kick(input int addr, input int t);
    @(negedge clk);
    rd_cnt = 0; end_cnt = 0;
    start = 1'b1; start_addr = AW'(addr); tempo = 5'(t);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 20000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    check("R1 busy", int'(busy), 0);
    check("R1 tone", int'(tone_out), 0);
    check("R1 music_end", int'(music_end), 0);
    check("R1 mem_rd", int'(mem_rd), 0);
  endtask

  task automatic t_single;
    int n;
    kick(8'h00, 3);
    busy_len(n);
    check("R4 single note busy length", n, 4 + dur(3, 5));
    check("R2 read count", rd_cnt, 2);
    check("R2 first address", int'(rd_log[0]), 8'h00);
    check("R2 second address", int'(rd_log[1]), 8'h01);
    check("R8 end pulses", end_cnt, 1);
    check("R10 tone after end", int'(tone_out), 0);
  endtask

  task automatic t_zero_codes;
    int n0, n1;
    kick(8'h10, 0);
    busy_len(n0);
    check("R5 zero codes length", n0, 4 + dur(1, 1));
    kick(8'h14, 1);
    busy_len(n1);
    check("R5 zero equals one", n0, n1);
  endtask

  task automatic t_two_notes;
    int n;
    kick(8'h20, 2);
    busy_len(n);
    check("R4 back-to-back length", n, 4 + dur(2, 4) + dur(2, 3));
    check("R8 bit6 ignored, end pulses", end_cnt, 1);
    check("R2 read count two notes", rd_cnt, 4);
    check("R2 third address", int'(rd_log[2]), 8'h22);
    check("R8 no read after last", int'(rd_log[3]), 8'h23);
  endtask

  task automatic t_tone;
    int k, hi, lo, n;
    kick(8'h30, 1);
    k = 0;
    while (!tone_out && k < 5000) begin k++; @(negedge clk); end
    check("R6 first rise delay", k, 4 + MUL * (8'h20 + 2));
    hi = 0;
    while (tone_out && hi < 5000) begin hi++; @(negedge clk); end
    check("R6 high phase", hi, MUL * (8'h20 + 2));
    lo = 0;
    while (!tone_out && lo < 5000) begin lo++; @(negedge clk); end
    check("R6 low phase", lo, MUL * (8'h20 + 2));
    busy_len(n);
    check("R10 tone low at idle", int'(tone_out), 0);
  endtask

  task automatic t_rest;
    int n, h;
    kick(8'h40, 1);
    n = 0; h = 0;
    while (busy && n < 20000) begin
      n++;
      if (tone_out) h++;
      @(negedge clk);
    end
    check("R7 rest keeps tone low", h, 0);
    check("R7 rest length", n, 4 + dur(1, 10));
  endtask

  task automatic t_start_busy;
    int n;
    kick(8'h00, 3);
    repeat (50) @(negedge clk);
    start = 1'b1; start_addr = 8'h50; tempo = 5'd1;
    @(negedge clk);
    start = 1'b0;
    busy_len(n);
    check("R3 busy length unchanged", n + 51, 4 + dur(3, 5));
    check("R3 reads unchanged", rd_cnt, 2);
    check("R3 addresses unchanged", int'(rd_log[1]), 8'h01);
  endtask

  task automatic t_stop_handover;
    kick(8'h50, 1);
    repeat (3 + dur(1, 5)) @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R9 busy after stop", int'(busy), 0);
    check("R9 tone after stop", int'(tone_out), 0);
    check("R9 no end pulse", int'(music_end), 0);
    repeat (30) @(negedge clk);
    check("R9 no read after stop", rd_cnt, 4);
    check("R10 still idle", int'(busy) + int'(tone_out), 0);
  endtask

  task automatic t_stop_tone;
    int k;
    kick(8'h30, 1);
    k = 0;
    while (!tone_out && k < 5000) begin k++; @(negedge clk); end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    check("R9 stop silences tone", int'(tone_out), 0);
    check("R9 stop clears busy", int'(busy), 0);
  endtask

  task automatic t_restart;
    int n;
    kick(8'h10, 0);
    busy_len(n);
    check("R2 restart after stop", n, 4 + dur(1, 1));
    check("R2 restart address", int'(rd_log[0]), 8'h10);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
    rom[8'h00] = 8'h85; rom[8'h01] = 8'h04;
    rom[8'h10] = 8'h80; rom[8'h11] = 8'h04;
    rom[8'h14] = 8'h81; rom[8'h15] = 8'h04;
    rom[8'h20] = 8'h44; rom[8'h21] = 8'h10;
    rom[8'h22] = 8'h83; rom[8'h23] = 8'h22;
    rom[8'h30] = 8'hBF; rom[8'h31] = 8'h20;
    rom[8'h40] = 8'h8A; rom[8'h41] = 8'h03;
    rom[8'h50] = 8'h05; rom[8'h51] = 8'h10;
    rom[8'h52] = 8'h03; rom[8'h53] = 8'h10;
    rom[8'h54] = 8'h85; rom[8'h55] = 8'h10;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_zero_codes();
    t_two_notes();
    t_tone();
    t_rest();
    t_start_busy();
    t_stop_handover();
    t_stop_tone();
    t_restart();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule